// File: doc/BRIEF.md
# SPI Byte Engine with Multi-Host Bus-Claim Detection

This block is a single-byte SPI shifter that can run in either of two roles. In the host role it drives SCK and MOSI and shifts one byte in mode 0: SCK idles low, MISO is sampled on the rising edge, and MOSI moves on the falling edge, most significant bit first. In the client role it follows an external SCK while its select line is low, and drives MISO. A small register port holds the role bit, the configuration bits, the transmit byte and an interrupt flag.

Several hosts may share one bus. When the select line is configured as an input, the select-disable bit is clear and the block is host, a stable low on SS means another host has claimed the bus. The block then drops to the client role, stops driving SCK and MOSI, and turns MISO around as a client output. It aborts any byte in flight without a completion pulse and sets the interrupt flag. Software must write the host bit again to take the bus back.

The role is a two-state machine. `ROLE_CLIENT` moves to `ROLE_HOST` on a control write with the host bit set. `ROLE_HOST` moves to `ROLE_CLIENT` on a bus-claim fault, or on a control write with the host bit clear. The shifter is a five-state machine:
- `ENG_IDLE` moves to `ENG_H_LOW` on a data write in the host role. It moves to `ENG_C_RUN` when the block is client and selected.
- `ENG_H_LOW` (SCK low half) moves to `ENG_H_HIGH` at the end of the half period.
- `ENG_H_HIGH` (SCK high half) returns to `ENG_H_LOW`, or moves to `ENG_FINISH` after the eighth bit.
- `ENG_C_RUN` moves to `ENG_FINISH` on the eighth SCK falling edge.
- `ENG_FINISH` returns to `ENG_IDLE` after one cycle.
- Loss of role, or deselection, sends a busy state back to `ENG_IDLE`.

Top module: `spi_mhost_ctrl`

## Requirements
- R1: Register map: writing address 0 sets the control bits (bit0 host role, bit1 select-disable, bit2 SS-is-output, bit3 interrupt enable). Address 1 holds the flag in bit0. Writing address 2 loads the transmit byte. Reads of addresses 0 and 1 return those bits. After reset, all control bits and the flag are 0, irq is 0, sck_oe and mosi_oe are 0, and sck_o is low.
- R2: In the host role, a write to address 2 shifts that byte out on mosi_o, MSB first. SCK idles low, and each SCK half period lasts SCK_HALF clocks. The byte sampled from miso_i on the eight rising edges appears on rx_data with a one-cycle xfer_done pulse, and the flag is set.
- R3: With the block host, select-disable 0 and SS-is-output 0, SS held low for two consecutive synchronized samples clears the host bit and sets the flag. This happens on the fourth clock edge after SS falls.
- R4: While host, sck_oe and mosi_oe are 1 and miso_oe is 0. While client, sck_oe and mosi_oe are 0, and miso_oe is 1 whenever the synchronized SS is low.
- R5: irq is 1 exactly when the flag, the interrupt enable bit and the gie input are all 1.
- R6: With SS-is-output set, a low SS never changes the role or the flag.
- R7: With select-disable set, a low SS never changes the role or the flag.
- R8: After a fault, the host bit stays 0, even when SS returns high, until software writes 1 to it. Writing 1 restores the host role.
- R9: A low pulse on ss_i lasting one clock period causes no fault. A low lasting two periods does cause one.
- R10: A fault during a host byte stops SCK and gives no xfer_done for that byte.
- R11: Writing 1 to flag bit0 clears the flag. If a fault or completion sets the flag in the same cycle, the flag stays 1.
- R12: As client, while SS is low, the block shifts the last written transmit byte out on miso_o, MSB first, and takes eight bits from mosi_i on the SCK rising edges. It then presents the byte on rx_data with xfer_done and sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| gie | input | 1 | Global interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for addresses 0 and 1 |
| rx_data | output | DW | Last received byte |
| xfer_done | output | 1 | One-cycle byte-complete pulse |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | SCK pin input |
| sck_o | output | 1 | SCK pin output |
| sck_oe | output | 1 | SCK output enable |
| mosi_i | input | 1 | MOSI pin input |
| mosi_o | output | 1 | MOSI pin output |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pin input |
| miso_o | output | 1 | MISO pin output |
| miso_oe | output | 1 | MISO output enable |
| ss_i | input | 1 | Slave-select pin level |

## Verification
The flag can be set by a fault and cleared by a software write in the same clock cycle. The bench drops SS and counts the synchronizer latency. It then holds a flag-clear write exactly over the fourth edge, where the fault registers. The flag must read 1 and the host bit 0 just after that edge, and the host bit must still read 1 one cycle earlier.

// File: rtl/spi_mh_pkg.sv
package spi_mh_pkg;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_H_LOW,
        ENG_H_HIGH,
        ENG_C_RUN,
        ENG_FINISH
    } eng_state_e;

    typedef enum logic {
        ROLE_CLIENT,
        ROLE_HOST
    } role_e;

    localparam int CTL_HOST   = 0;
    localparam int CTL_SELDIS = 1;
    localparam int CTL_SSOUT  = 2;
    localparam int CTL_IE     = 3;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_FLAG = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

endpackage

// File: rtl/spi_mh_sync.sv
module spi_mh_sync #(
    parameter int   STAGES  = 3,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic now_q,
    output logic prev_q
);
    logic [STAGES-1:0] stage_q;

    // stage 0 takes the pin; each later stage takes its neighbour
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign now_q  = stage_q[STAGES-2];
    assign prev_q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_mh_regs.sv
module spi_mh_regs
    import spi_mh_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          ss_low_stable,
    input  logic          xfer_done,
    input  logic          gie,
    output logic          host_en,
    output logic          sel_dis,
    output logic          ss_out,
    output logic          irq_en,
    output logic          flag,
    output logic          irq,
    output logic          fault,
    output logic          start,
    output logic [DW-1:0] tx_buf,
    output logic [DW-1:0] reg_rdata
);
    role_e role_q, role_d;
    logic  sel_dis_q, ss_out_q, irq_en_q, flag_q;
    logic  ctl_wr, flag_wr, data_wr;

    assign ctl_wr  = reg_wr && (reg_addr == ADDR_CTRL);
    assign flag_wr = reg_wr && (reg_addr == ADDR_FLAG);
    assign data_wr = reg_wr && (reg_addr == ADDR_DATA);

    // another host claims the bus through an input-configured select line
    assign fault = (role_q == ROLE_HOST) && !sel_dis_q && !ss_out_q && ss_low_stable;

    always_comb begin
        role_d = role_q;
        unique case (role_q)
            ROLE_CLIENT: if (ctl_wr && reg_wdata[CTL_HOST]) role_d = ROLE_HOST;
            ROLE_HOST: begin
                if (fault)                                   role_d = ROLE_CLIENT;
                else if (ctl_wr && !reg_wdata[CTL_HOST])     role_d = ROLE_CLIENT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) role_q <= ROLE_CLIENT;
        else        role_q <= role_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_dis_q <= 1'b0;
            ss_out_q  <= 1'b0;
            irq_en_q  <= 1'b0;
        end else if (ctl_wr) begin
            sel_dis_q <= reg_wdata[CTL_SELDIS];
            ss_out_q  <= reg_wdata[CTL_SSOUT];
            irq_en_q  <= reg_wdata[CTL_IE];
        end
    end

    // setting has priority over the write-one clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      flag_q <= 1'b0;
        else if (fault || xfer_done)     flag_q <= 1'b1;
        else if (flag_wr && reg_wdata[0]) flag_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tx_buf <= '0;
        else if (data_wr) tx_buf <= reg_wdata;
    end

    always_comb begin
        host_en = (role_q == ROLE_HOST);
        sel_dis = sel_dis_q;
        ss_out  = ss_out_q;
        irq_en  = irq_en_q;
        flag    = flag_q;
        irq     = flag_q & irq_en_q & gie;
        start   = data_wr && (role_q == ROLE_HOST) && !fault;
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CTL_HOST]   = (role_q == ROLE_HOST);
                reg_rdata[CTL_SELDIS] = sel_dis_q;
                reg_rdata[CTL_SSOUT]  = ss_out_q;
                reg_rdata[CTL_IE]     = irq_en_q;
            end
            ADDR_FLAG: reg_rdata[0] = flag_q;
            default:   reg_rdata    = '0;
        endcase
    end
endmodule

// File: rtl/spi_mh_shifter.sv
module spi_mh_shifter
    import spi_mh_pkg::*;
#(
    parameter int DW   = 8,
    parameter int HALF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_role,
    input  logic          start,
    input  logic [DW-1:0] start_data,
    input  logic [DW-1:0] idle_data,
    input  logic          client_sel,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          mosi_in,
    input  logic          miso_in,
    output logic          sck_o,
    output logic          mosi_o,
    output logic          miso_o,
    output logic [DW-1:0] rx_data,
    output logic          done
);
    localparam int CW   = (DW > 1) ? $clog2(DW) : 1;
    localparam int DIVW = $clog2(HALF + 1);

    eng_state_e      state_q, state_d;
    logic [DIVW-1:0] div_q;
    logic [CW-1:0]   bit_q;
    logic [DW-1:0]   sh_q;
    logic            samp_q;
    logic            half_end, last_bit;

    assign half_end = (div_q == DIVW'(HALF - 1));
    assign last_bit = (bit_q == CW'(DW - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE: begin
                if (host_role && start)            state_d = ENG_H_LOW;
                else if (!host_role && client_sel) state_d = ENG_C_RUN;
            end
            ENG_H_LOW: begin
                if (!host_role)    state_d = ENG_IDLE;
                else if (half_end) state_d = ENG_H_HIGH;
            end
            ENG_H_HIGH: begin
                if (!host_role)    state_d = ENG_IDLE;
                else if (half_end) state_d = last_bit ? ENG_FINISH : ENG_H_LOW;
            end
            ENG_C_RUN: begin
                if (host_role || !client_sel) state_d = ENG_IDLE;
                else if (sck_fall && last_bit) state_d = ENG_FINISH;
            end
            ENG_FINISH: state_d = ENG_IDLE;
            default:    state_d = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENG_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            samp_q  <= 1'b0;
            rx_data <= '0;
        end else begin
            unique case (state_q)
                ENG_IDLE: begin
                    div_q <= '0;
                    bit_q <= '0;
                    if (state_d == ENG_H_LOW)      sh_q <= start_data;
                    else if (state_d == ENG_C_RUN) sh_q <= idle_data;
                end
                ENG_H_LOW: begin
                    if (half_end) begin
                        div_q  <= '0;
                        samp_q <= miso_in;
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                ENG_H_HIGH: begin
                    if (half_end) begin
                        div_q <= '0;
                        sh_q  <= {sh_q[DW-2:0], samp_q};
                        bit_q <= bit_q + 1'b1;
                        if (last_bit) rx_data <= {sh_q[DW-2:0], samp_q};
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                ENG_C_RUN: begin
                    if (sck_rise) samp_q <= mosi_in;
                    if (sck_fall) begin
                        sh_q  <= {sh_q[DW-2:0], samp_q};
                        bit_q <= bit_q + 1'b1;
                        if (last_bit) rx_data <= {sh_q[DW-2:0], samp_q};
                    end
                end
                ENG_FINISH: begin
                    div_q <= '0;
                    bit_q <= '0;
                end
                default: begin
                    div_q <= '0;
                    bit_q <= '0;
                end
            endcase
        end
    end

    always_comb begin
        sck_o  = (state_q == ENG_H_HIGH);
        mosi_o = sh_q[DW-1];
        miso_o = sh_q[DW-1];
        done   = (state_q == ENG_FINISH);
    end
endmodule

// File: rtl/spi_mhost_ctrl.sv
module spi_mhost_ctrl
    import spi_mh_pkg::*;
#(
    parameter int DW       = 8,
    parameter int SCK_HALF = 4,
    parameter int SYNC_LEN = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gie,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic [DW-1:0] rx_data,
    output logic          xfer_done,
    output logic          irq,
    input  logic          sck_i,
    output logic          sck_o,
    output logic          sck_oe,
    input  logic          mosi_i,
    output logic          mosi_o,
    output logic          mosi_oe,
    input  logic          miso_i,
    output logic          miso_o,
    output logic          miso_oe,
    input  logic          ss_i
);
    logic          ss_now, ss_prev, sck_now, sck_prev;
    logic          ss_low_stable, client_sel;
    logic          host_en, sel_dis, ss_out, irq_en, flag, fault, start;
    logic [DW-1:0] tx_buf;
    logic          sck_rise, sck_fall;

    spi_mh_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_ss_sync (
        .clk(clk), .rst_n(rst_n), .d(ss_i), .now_q(ss_now), .prev_q(ss_prev)
    );

    spi_mh_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b0)) u_sck_sync (
        .clk(clk), .rst_n(rst_n), .d(sck_i), .now_q(sck_now), .prev_q(sck_prev)
    );

    // two consecutive low samples are needed before a claim counts
    assign ss_low_stable = !ss_now && !ss_prev;
    assign client_sel    = !ss_now;
    assign sck_rise      = sck_now && !sck_prev;
    assign sck_fall      = !sck_now && sck_prev;

    spi_mh_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .ss_low_stable(ss_low_stable),
        .xfer_done(xfer_done), .gie(gie), .host_en(host_en), .sel_dis(sel_dis),
        .ss_out(ss_out), .irq_en(irq_en), .flag(flag), .irq(irq), .fault(fault),
        .start(start), .tx_buf(tx_buf), .reg_rdata(reg_rdata)
    );

    spi_mh_shifter #(.DW(DW), .HALF(SCK_HALF)) u_shift (
        .clk(clk), .rst_n(rst_n), .host_role(host_en), .start(start),
        .start_data(reg_wdata), .idle_data(tx_buf), .client_sel(client_sel),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_in(mosi_i),
        .miso_in(miso_i), .sck_o(sck_o), .mosi_o(mosi_o), .miso_o(miso_o),
        .rx_data(rx_data), .done(xfer_done)
    );

    assign sck_oe  = host_en;
    assign mosi_oe = host_en;
    assign miso_oe = !host_en && client_sel;
endmodule

// File: rtl/spi_mhost_ctrl_chk.sv
module spi_mhost_ctrl_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          gie,
    input logic          reg_wr,
    input logic [1:0]    reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic          xfer_done,
    input logic          irq,
    input logic          sck_oe,
    input logic          mosi_oe,
    input logic          miso_oe,
    input logic          host_en,
    input logic          sel_dis,
    input logic          ss_out,
    input logic          irq_en,
    input logic          flag,
    input logic          fault,
    input logic          ss_low_stable
);
    logic ctl_wr, clr_wr;
    assign ctl_wr = reg_wr && (reg_addr == 2'd0);
    assign clr_wr = reg_wr && (reg_addr == 2'd1) && reg_wdata[0];

    // R3
    claim_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en && !sel_dis && !ss_out && ss_low_stable) |=> (!host_en && flag));

    // R4
    client_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_en |-> (!sck_oe && !mosi_oe));

    // R4
    host_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_en |-> !miso_oe);

    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && irq_en && gie));

    // R6
    ss_output_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en && ss_out && !ctl_wr) |=> host_en);

    // R7
    sel_dis_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en && sel_dis && !ctl_wr) |=> host_en);

    // R8
    no_auto_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_en && !(ctl_wr && reg_wdata[0])) |=> !host_en);

    // R11
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault || xfer_done) && clr_wr) |=> flag);

    // R11
    clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !fault && !xfer_done) |=> !flag);
endmodule

bind spi_mhost_ctrl spi_mhost_ctrl_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .gie(gie), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .xfer_done(xfer_done), .irq(irq), .sck_oe(sck_oe),
    .mosi_oe(mosi_oe), .miso_oe(miso_oe), .host_en(host_en), .sel_dis(sel_dis),
    .ss_out(ss_out), .irq_en(irq_en), .flag(flag), .fault(fault),
    .ss_low_stable(ss_low_stable)
);

// File: tb/test_spi_mhost_ctrl.sv
`timescale 1ns/100ps
module test_spi_mhost_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gie = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata, rx_data;
    logic       xfer_done, irq;
    logic       sck_i = 1'b0, sck_o, sck_oe;
    logic       mosi_i = 1'b0, mosi_o, mosi_oe;
    logic       miso_i, miso_o, miso_oe;
    logic       ss_i = 1'b1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    spi_mhost_ctrl i_spi_mhost_ctrl (
        .clk(clk), .rst_n(rst_n), .gie(gie), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_data(rx_data),
        .xfer_done(xfer_done), .irq(irq), .sck_i(sck_i), .sck_o(sck_o),
        .sck_oe(sck_oe), .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_i(ss_i)
    );

    // external client model for host transfers
    logic [7:0] resp_byte = 8'd0;
    logic [7:0] mosi_cap  = 8'd0;
    logic [2:0] rise_idx  = 3'd0;
    always @(posedge sck_o or negedge sck_oe) begin
        if (!sck_oe) rise_idx = 3'd0;
        else begin
            mosi_cap = {mosi_cap[6:0], mosi_o};
            rise_idx = rise_idx + 3'd1;
        end
    end
    assign miso_i = resp_byte[3'd7 - rise_idx];

    typedef struct {
        logic [7:0] rx;
        logic [7:0] mo;
        bit         chk_mo;
    } exp_t;
    exp_t sbq[$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops expected bytes as the design completes them
    always @(negedge clk) begin
        if (rst_n && xfer_done) begin
            if (sbq.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R10: actual xfer_done=1 expected no completion");
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk("R2/R12 rx_data", rx_data, e.rx);
                if (e.chk_mo) chk("R2 mosi byte", mosi_cap, e.mo);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_empty();
        for (int k = 0; k < 400; k++) begin
            if (sbq.size() == 0) break;
            @(negedge clk);
        end
        chk("R2/R12 byte completed", sbq.size(), 0);
    endtask

    task automatic host_xfer(input logic [7:0] tx, input logic [7:0] rsp);
        exp_t e;
        resp_byte = rsp;
        e.rx = rsp; e.mo = tx; e.chk_mo = 1'b1;
        sbq.push_back(e);
        wr(2'd2, tx);
        wait_empty();
    endtask

    task automatic client_xfer(input logic [7:0] mi, input logic [7:0] exp_out);
        exp_t e;
        logic [7:0] cap;
        cap = 8'd0;
        e.rx = mi; e.mo = 8'd0; e.chk_mo = 1'b0;
        sbq.push_back(e);
        for (int b = 7; b >= 0; b--) begin
            mosi_i = mi[b];
            repeat (6) @(negedge clk);
            cap = {cap[6:0], miso_o};
            sck_i = 1'b1;
            repeat (6) @(negedge clk);
            sck_i = 1'b0;
        end
        repeat (8) @(negedge clk);
        chk("R12 client completed", sbq.size(), 0);
        chk("R12 miso byte", cap, exp_out);
    endtask

    task automatic report();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual run not finished expected finished");
        report();
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(2'd0, r); chk("R1 ctrl after reset", r, 8'h00);
        rd(2'd1, r); chk("R1 flag after reset", r, 8'h00);
        chk("R1 irq", irq, 0);
        chk("R1 sck_oe", sck_oe, 0);
        chk("R1 mosi_oe", mosi_oe, 0);
        chk("R1 sck_o", sck_o, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // host role with interrupt enable
        wr(2'd0, 8'h09);
        #1;
        chk("R4 sck_oe host", sck_oe, 1);
        chk("R4 mosi_oe host", mosi_oe, 1);
        chk("R4 miso_oe host", miso_oe, 0);

        // R2 two byte patterns
        host_xfer(8'hA5, 8'h3C);
        host_xfer(8'h0F, 8'hC6);
        #1;
        chk("R2 sck idle low", sck_o, 0);
        rd(2'd1, r); chk("R2 flag set", r[0], 1);
        chk("R5 irq all set", irq, 1);

        // R5 gating
        gie = 1'b0; #1; chk("R5 irq gie off", irq, 0);
        gie = 1'b1; #1; chk("R5 irq gie on", irq, 1);
        wr(2'd0, 8'h01); #1; chk("R5 irq ie off", irq, 0);
        wr(2'd0, 8'h09);

        // R11 write-one clear
        wr(2'd1, 8'h01);
        rd(2'd1, r); chk("R11 flag cleared", r[0], 0);
        chk("R5 irq flag off", irq, 0);

        // R6 SS as output
        wr(2'd0, 8'h0D);
        @(negedge clk) ss_i = 1'b0;
        repeat (10) @(negedge clk);
        rd(2'd0, r); chk("R6 host kept", r[0], 1);
        rd(2'd1, r); chk("R6 flag untouched", r[0], 0);
        ss_i = 1'b1;
        repeat (4) @(negedge clk);

        // R7 select disable
        wr(2'd0, 8'h0B);
        @(negedge clk) ss_i = 1'b0;
        repeat (10) @(negedge clk);
        rd(2'd0, r); chk("R7 host kept", r[0], 1);
        rd(2'd1, r); chk("R7 flag untouched", r[0], 0);
        ss_i = 1'b1;
        repeat (4) @(negedge clk);

        // R9 single-cycle glitch
        wr(2'd0, 8'h09);
        @(negedge clk) ss_i = 1'b0;
        @(negedge clk) ss_i = 1'b1;
        repeat (6) @(negedge clk);
        rd(2'd0, r); chk("R9 glitch ignored", r[0], 1);
        rd(2'd1, r); chk("R9 glitch no flag", r[0], 0);

        // R9 two-cycle low faults
        @(negedge clk) ss_i = 1'b0;
        repeat (2) @(negedge clk);
        ss_i = 1'b1;
        repeat (6) @(negedge clk);
        rd(2'd0, r); chk("R9 two-cycle low faults", r[0], 0);
        rd(2'd1, r); chk("R9 flag on fault", r[0], 1);
        repeat (10) @(negedge clk);
        rd(2'd0, r); chk("R8 host stays cleared", r[0], 0);
        chk("R4 sck_oe client", sck_oe, 0);
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h09);
        rd(2'd0, r); chk("R8 software re-enables", r[0], 1);

        // R3 exact latency, R11 set beats clear in same cycle
        @(negedge clk) ss_i = 1'b0;
        repeat (3) @(negedge clk);
        rd(2'd0, r); chk("R3 host before fault edge", r[0], 1);
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h01;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(2'd0, r); chk("R3 host cleared at fourth edge", r[0], 0);
        rd(2'd1, r); chk("R11 set wins over clear", r[0], 1);
        chk("R4 sck_oe after fault", sck_oe, 0);
        chk("R4 mosi_oe after fault", mosi_oe, 0);
        chk("R4 miso_oe after fault", miso_oe, 1);
        chk("R5 irq on fault", irq, 1);
        ss_i = 1'b1;
        repeat (6) @(negedge clk);
        rd(2'd0, r); chk("R8 host stays cleared after SS high", r[0], 0);
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h09);

        // R10 abort mid-byte, then R12 client transfer of the same byte
        resp_byte = 8'h99;
        wr(2'd2, 8'hC3);
        repeat (20) @(negedge clk);
        ss_i = 1'b0;
        repeat (8) @(negedge clk);
        rd(2'd0, r); chk("R10 host dropped", r[0], 0);
        chk("R10 sck stopped", sck_o, 0);
        chk("R10 sck_oe off", sck_oe, 0);
        wr(2'd1, 8'h01);
        rd(2'd1, r); chk("R10 flag cleared before client byte", r[0], 0);
        client_xfer(8'h5A, 8'hC3);
        rd(2'd1, r); chk("R12 flag after client byte", r[0], 1);
        chk("R4 miso_oe client selected", miso_oe, 1);
        ss_i = 1'b1;
        repeat (6) @(negedge clk);
        chk("R4 miso_oe deselected", miso_oe, 0);

        // R8 host works again after re-enable
        wr(2'd0, 8'h09);
        host_xfer(8'h81, 8'h7E);

        repeat (4) @(negedge clk);
        report();
    end
endmodule